// File: doc/BRIEF.md
# Bus-Organized Register File Datapath

This block is the data half of a small processor. It holds seven general-purpose registers. Two source multiplexers feed them into a single shared ALU. One control word per clock cycle sets everything the datapath does in that cycle: which operands are read, which operation runs, and which register, if any, keeps the result.

Either source multiplexer can take the external data input instead of a register, and that is how outside values enter the register set. The ALU result always drives the external output. A destination decoder loads the result into at most one register on the rising clock edge. A control sequencer outside the block issues the control words. This block does no sequencing, has no memory and does not branch on flags.

Top module: `regbus_datapath`

## Requirements
- R1: The 14-bit control word is split, from the most significant bit down, as source A select [13:11], source B select [10:8], destination select [7:5] and operation code [4:0].
- R2: A source select value k from 1 to 7 places register Rk on its operand bus. The value 0 places the external data input on that bus.
- R3: A destination select of 0 loads no register. The result still appears on the external output.
- R4: A destination select k from 1 to 7 loads the result into Rk on the rising clock edge. Every other register keeps its value.
- R5: The operation codes are as follows, with arithmetic taken modulo 2^DATA_W:
  - 00000 passes A through.
  - 00001 gives A+1.
  - 00010 gives A+B.
  - 00101 gives A-B.
  - 00110 gives A-1.
  - 01000 gives A AND B.
  - 01010 gives A OR B.
  - 01100 gives A XOR B.
  - 01110 gives NOT A.
  - 10000 gives A shifted right by one, with a zero shifted in.
  - 11000 gives A shifted left by one, with a zero shifted in.
- R6: Every operation code not listed in R5 gives a result of zero.
- R7: While the synchronous active-high reset is sampled high at a rising edge, all seven registers become zero.
- R8: When a source select names the same register as the destination, the operation reads the old value. The new value can be read from the next cycle onward.
- R9: The external output follows the current control word, register contents and external input within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Control word for the current cycle |
| ext_in | input | DATA_W | External data input, selected by source code 0 |
| ext_out | output | DATA_W | ALU result for the current cycle |

## Verification
Two things happen in one cycle when an operation reads a register and also names that register as its destination. The combinational read then meets the edge-triggered write. The bench provokes this with directed accumulate steps on one register, and it also meets the case often under random control words. The check has two parts. The output in the collision cycle must use the old value. The next cycle's read through transfer-A with no destination must show the new value. A second overlap is a write with destination 0 in the same cycle as a visible result. The bench judges this by reading every register back afterwards.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int SEL_W  = 3;
  localparam int OPR_W  = 5;
  localparam int CW_W   = 3 * SEL_W + OPR_W;
  localparam int NREG   = (1 << SEL_W) - 1;

  localparam logic [OPR_W-1:0] OP_PASS = 5'b00000;
  localparam logic [OPR_W-1:0] OP_INC  = 5'b00001;
  localparam logic [OPR_W-1:0] OP_ADD  = 5'b00010;
  localparam logic [OPR_W-1:0] OP_SUB  = 5'b00101;
  localparam logic [OPR_W-1:0] OP_DEC  = 5'b00110;
  localparam logic [OPR_W-1:0] OP_AND  = 5'b01000;
  localparam logic [OPR_W-1:0] OP_OR   = 5'b01010;
  localparam logic [OPR_W-1:0] OP_XOR  = 5'b01100;
  localparam logic [OPR_W-1:0] OP_NOT  = 5'b01110;
  localparam logic [OPR_W-1:0] OP_SHR  = 5'b10000;
  localparam logic [OPR_W-1:0] OP_SHL  = 5'b11000;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OPR_W-1:0] op;
  } ctrl_t;
endpackage

// File: rtl/regbus_decode.sv
module regbus_decode
  import regbus_pkg::*;
(
  input  logic [CW_W-1:0]  ctrl_word,
  output logic [SEL_W-1:0] src_a,
  output logic [SEL_W-1:0] src_b,
  output logic [OPR_W-1:0] op,
  output logic [NREG-1:0]  wr_sel
);
  ctrl_t cw;
  assign cw    = ctrl_t'(ctrl_word);
  assign src_a = cw.src_a;
  assign src_b = cw.src_b;
  assign op    = cw.op;

  // one enable per register; code 0 leaves all enables low
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_sel[i] = (cw.dst == SEL_W'(i + 1));
  end
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DATA_W-1:0]      ext_in,
  input  logic [SEL_W-1:0]       src_a,
  input  logic [SEL_W-1:0]       src_b,
  input  logic [NREG-1:0]        wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [DATA_W-1:0]      bus_a,
  output logic [DATA_W-1:0]      bus_b,
  output logic [NREG*DATA_W-1:0] reg_flat
);
  localparam int NSRC = NREG + 1;

  // slot 0 of the source table is the external input
  logic [DATA_W-1:0] src_tbl [NSRC];
  assign src_tbl[0] = ext_in;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)            q <= '0;
      else if (wr_sel[i]) q <= wr_data;
    end
    assign src_tbl[i+1]                   = q;
    assign reg_flat[i*DATA_W +: DATA_W]   = q;
  end

  assign bus_a = src_tbl[src_a];
  assign bus_b = src_tbl[src_b];
endmodule

// File: rtl/regbus_alu.sv
module regbus_alu
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OPR_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic [DATA_W-1:0] alu_eval(
    input logic [OPR_W-1:0]  f,
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z
  );
    case (f)
      OP_PASS: return x;
      OP_INC:  return x + ONE;
      OP_ADD:  return x + z;
      OP_SUB:  return x - z;
      OP_DEC:  return x - ONE;
      OP_AND:  return x & z;
      OP_OR:   return x | z;
      OP_XOR:  return x ^ z;
      OP_NOT:  return ~x;
      OP_SHR:  return x >> 1;
      OP_SHL:  return x << 1;
      default: return '0;
    endcase
  endfunction

  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] ext_out
);
  logic [SEL_W-1:0]       src_a;
  logic [SEL_W-1:0]       src_b;
  logic [OPR_W-1:0]       op;
  logic [NREG-1:0]        wr_sel;
  logic [DATA_W-1:0]      bus_a;
  logic [DATA_W-1:0]      bus_b;
  logic [DATA_W-1:0]      alu_y;
  logic [NREG*DATA_W-1:0] reg_flat;

  regbus_decode u_dec (
    .ctrl_word(ctrl_word),
    .src_a(src_a),
    .src_b(src_b),
    .op(op),
    .wr_sel(wr_sel)
  );

  regbus_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk),
    .rst(rst),
    .ext_in(ext_in),
    .src_a(src_a),
    .src_b(src_b),
    .wr_sel(wr_sel),
    .wr_data(alu_y),
    .bus_a(bus_a),
    .bus_b(bus_b),
    .reg_flat(reg_flat)
  );

  regbus_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op),
    .a(bus_a),
    .b(bus_b),
    .y(alu_y)
  );

  assign ext_out = alu_y;
endmodule

// File: rtl/regbus_datapath_chk.sv
module regbus_datapath_chk
  import regbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [CW_W-1:0]        ctrl_word,
  input logic [DATA_W-1:0]      ext_in,
  input logic [DATA_W-1:0]      ext_out,
  input logic [NREG-1:0]        wr_sel,
  input logic [NREG*DATA_W-1:0] reg_flat
);
  // R4
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  // R3
  no_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[7:5] == 3'd0) |-> (wr_sel == '0));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (reg_flat == '0));

  // R2
  ext_path_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[13:11] == 3'd0 && ctrl_word[4:0] == OP_PASS) |-> (ext_out == ext_in));

  for (genvar k = 0; k < NREG; k++) begin : g_reg_chk
    // R4
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
      wr_sel[k] |=> (reg_flat[k*DATA_W +: DATA_W] == $past(ext_out)));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[k] |=> $stable(reg_flat[k*DATA_W +: DATA_W]));
  end
endmodule

bind regbus_datapath regbus_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .ctrl_word(ctrl_word),
  .ext_in(ext_in),
  .ext_out(ext_out),
  .wr_sel(wr_sel),
  .reg_flat(reg_flat)
);

// File: tb/tb_regbus_datapath.sv
module tb_regbus_datapath;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [13:0]   ctrl_word = '0;
  logic [DW-1:0] ext_in = '0;
  logic [DW-1:0] ext_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [8];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #2 clk = ~clk;

  regbus_datapath #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in), .ext_out(ext_out)
  );

  // independent restatement of R5/R6
  function automatic logic [DW-1:0] ref_op(input logic [4:0] f,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
    logic [DW:0] wide;
    case (f)
      5'd0:  ref_op = a;
      5'd1:  begin wide = {1'b0, a} + 1; ref_op = wide[DW-1:0]; end
      5'd2:  begin wide = {1'b0, a} + {1'b0, b}; ref_op = wide[DW-1:0]; end
      5'd5:  ref_op = a + ~b + 1'b1;
      5'd6:  ref_op = a + {DW{1'b1}};
      5'd8:  ref_op = a & b;
      5'd10: ref_op = a | b;
      5'd12: ref_op = (a | b) & ~(a & b);
      5'd14: ref_op = a ^ {DW{1'b1}};
      5'd16: ref_op = {1'b0, a[DW-1:1]};
      5'd24: ref_op = {a[DW-2:0], 1'b0};
      default: ref_op = '0;
    endcase
  endfunction

  function automatic logic [13:0] mk(input int sa, input int sb, input int sd, input int f);
    mk = {3'(sa), 3'(sb), 3'(sd), 5'(f)};
  endfunction

  // driver: applies one control word and queues the expected output
  task automatic apply(input logic [13:0] cw, input logic [DW-1:0] din, input string tag);
    logic [DW-1:0] a, b, r;
    @(negedge clk);
    ctrl_word = cw;
    ext_in    = din;
    a = (cw[13:11] == 3'd0) ? din : model[cw[13:11]];
    b = (cw[10:8]  == 3'd0) ? din : model[cw[10:8]];
    r = ref_op(cw[4:0], a, b);
    exp_q.push_back(r);
    tag_q.push_back(tag);
    if (cw[7:5] != 3'd0) model[cw[7:5]] = r;
  endtask

  // monitor: compares one queued item per cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (ext_out !== e) begin
          errors++;
          $display("FAIL %s: ext_out=%h expected=%h", t, ext_out, e);
        end
      end
    end
  end

  task automatic read_all(input string tag);
    for (int k = 1; k < 8; k++) apply(mk(k, 0, 0, 0), 8'h00, tag);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7: every register reads zero after reset
    read_all("R7");

    // R2 / R9: external input straight to output
    apply(mk(0, 0, 0, 0), 8'hA5, "R2");
    apply(mk(0, 0, 0, 0), 8'h3C, "R9");
    // R1 / R4: load distinct values into every register
    for (int k = 1; k < 8; k++) apply(mk(0, 0, k, 0), DW'(k * 17 + 3), "R4");
    read_all("R4");
    // R1: field placement — A from R2, B from R5, result into R6
    apply(mk(2, 5, 6, 2), 8'h00, "R1");
    apply(mk(6, 0, 0, 0), 8'h00, "R1");
    // R5: every listed operation with both buses on registers
    apply(mk(3, 4, 0, 0),  8'h00, "R5");
    apply(mk(3, 4, 0, 1),  8'h00, "R5");
    apply(mk(3, 4, 0, 2),  8'h00, "R5");
    apply(mk(3, 4, 0, 5),  8'h00, "R5");
    apply(mk(3, 4, 0, 6),  8'h00, "R5");
    apply(mk(3, 4, 0, 8),  8'h00, "R5");
    apply(mk(3, 4, 0, 10), 8'h00, "R5");
    apply(mk(3, 4, 0, 12), 8'h00, "R5");
    apply(mk(3, 4, 0, 14), 8'h00, "R5");
    apply(mk(3, 4, 0, 16), 8'h00, "R5");
    apply(mk(3, 4, 0, 24), 8'h00, "R5");
    // R5: wrap-around corners
    apply(mk(0, 0, 0, 1), 8'hFF, "R5");
    apply(mk(0, 0, 0, 6), 8'h00, "R5");
    apply(mk(0, 0, 0, 24), 8'h81, "R5");
    // R6: unlisted codes give zero, and write zero when targeted
    apply(mk(1, 2, 0, 3),  8'h00, "R6");
    apply(mk(1, 2, 0, 31), 8'h00, "R6");
    apply(mk(1, 2, 7, 17), 8'h00, "R6");
    apply(mk(7, 0, 0, 0),  8'h00, "R6");
    // R3: no-destination results leave every register untouched
    apply(mk(0, 1, 0, 12), 8'hF0, "R3");
    apply(mk(2, 3, 0, 2),  8'h11, "R3");
    read_all("R3");
    // R8: accumulate into the register being read
    apply(mk(0, 0, 3, 0), 8'h05, "R8");
    apply(mk(3, 3, 3, 2), 8'h00, "R8");
    apply(mk(3, 0, 0, 0), 8'h00, "R8");
    apply(mk(3, 3, 3, 2), 8'h00, "R8");
    apply(mk(3, 0, 0, 0), 8'h00, "R8");
    // random control words mixed with listed opcodes
    for (int n = 0; n < 400; n++) begin
      logic [13:0] cw;
      cw = 14'($urandom);
      if (n % 2 == 0) begin
        case ($urandom % 11)
          0: cw[4:0] = 5'd0;   1: cw[4:0] = 5'd1;   2: cw[4:0] = 5'd2;
          3: cw[4:0] = 5'd5;   4: cw[4:0] = 5'd6;   5: cw[4:0] = 5'd8;
          6: cw[4:0] = 5'd10;  7: cw[4:0] = 5'd12;  8: cw[4:0] = 5'd14;
          9: cw[4:0] = 5'd16;  default: cw[4:0] = 5'd24;
        endcase
      end
      apply(cw, DW'($urandom), "R5");
    end
    read_all("R4");
    // R7: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = '0;
    read_all("R7");
    @(negedge clk);
    @(negedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule